// File: doc/BRIEF.md
# Subset-Partitioned Register Renamer

This block renames a group of four instructions in one cycle for a clustered core whose physical register file is split into four subsets, each written by one cluster. The cluster, and so the target subset of every destination, has already been chosen when the group arrives. Each destination is therefore drawn from the free list of its own subset. The renamer counts how many destinations land in each subset and takes exactly that many entries from each list. No shared pool is used and no registers are recycled between lists.

Sources are turned into physical tags in the same cycle. A source that names a register written earlier in the same group gets that earlier instruction's new tag. Any other source reads the logical-to-physical table as it stood before the group. At the clock edge the table takes the group's new mappings. If any subset list is too short for the group, the whole group stalls and nothing changes. Retired physical registers come back on four release ports and are appended to the list that their subset bits select.

Physical tags are 9 bits wide. The top 2 bits give the subset and the low 7 bits give the index within it. There are 32 logical registers and 128 registers per subset. The rename outputs are combinational and valid in the cycle the group is presented. All state changes at the following clock edge.

Top module: `subset_renamer`

## Requirements
- R1: Each destination tag has its two top bits equal to that instruction's target subset (tag = subset*128 + index), and no two destinations of a renamed group share a tag.
- R2: Every subset list is first-in first-out. The instructions targeting subset s take the next entries of list s in program order, and exactly that many entries are removed when the group is accepted.
- R3: A source whose logical register is the destination of an earlier instruction in the group gets the tag of the latest such earlier instruction.
- R4: A source with no earlier writer in the group gets the tag held in the mapping table before the group.
- R5: When several instructions of a group write the same logical register, the table keeps the tag of the last one in program order.
- R6: With a valid group, the stall output is high in the same cycle whenever some subset list holds fewer entries than the group's demand on it. Counts are taken before that cycle's releases. A stalled group removes no entries and leaves the table unchanged.
- R7: A released tag is appended to the list its top two bits select. Several releases in one cycle are appended in port order (port 0 first). The entry can be handed out from the next cycle.
- R8: After reset, logical register r maps to tag (r mod 4)*128 + r/4, and list s holds indices 8 to 127 in ascending order.
- R9: While the group-valid input is low, the stall output is low, no entries are removed and the table is unchanged, whatever the destination inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| grp_valid | input | 1 | A rename group is presented this cycle |
| grp_src_a | input | 4x5 | First logical source of each instruction, slot 0 oldest |
| grp_src_b | input | 4x5 | Second logical source of each instruction |
| grp_dst | input | 4x5 | Logical destination of each instruction |
| grp_sub | input | 4x2 | Target subset of each destination |
| rel_valid | input | 4 | Release port valid bits |
| rel_tag | input | 4x9 | Physical tags returned to the free lists |
| grp_stall | output | 1 | Group cannot be renamed this cycle |
| phys_src_a | output | 4x9 | Physical tag of each first source |
| phys_src_b | output | 4x9 | Physical tag of each second source |
| phys_dst | output | 4x9 | New physical tag of each destination |

## Verification
A directed group chains writes and reads of the same logical registers. It tells in-group forwarding apart from table reads, and the last writer apart from earlier writers of a register. One subset is drained until a group stalls, and registers are released during the stalled cycle. This shows that the stall uses the counts from before the releases, that a stall leaves the table alone, and that released registers are handed back in port order. A long random stream then mixes subset vectors, repeated destinations, idle cycles and releases drawn from registers that are really displaced. Unbalanced demand across the four lists is compared against a queue model of each list.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int GRP_N      = 4;
  localparam int SUB_N      = 4;
  localparam int LREG_N     = 32;
  localparam int SUB_DEPTH  = 128;
  localparam int REL_N      = 4;
  localparam int SUB_W      = $clog2(SUB_N);
  localparam int IDX_W      = $clog2(SUB_DEPTH);
  localparam int TAG_W      = SUB_W + IDX_W;
  localparam int LREG_W     = $clog2(LREG_N);
endpackage

// File: rtl/rn_rst_sync.sv
module rn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int DEPTH = 128,
  parameter int RESV  = 8,
  parameter int NPOP  = 4,
  parameter int NPUSH = 4,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int NW   = $clog2(NPOP + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pop_en,
  input  logic [NW-1:0]               pop_num,
  input  logic [NPUSH-1:0]            push_vld,
  input  logic [NPUSH-1:0][IW-1:0]    push_idx,
  output logic [NPOP-1:0][IW-1:0]     pop_idx,
  output logic [CW-1:0]               avail
);
  logic [IW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] written_q, written_d;
  logic [IW-1:0]    head_q, head_d, tail_q, tail_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [NPOP-1:0][IW-1:0]  rd_slot;
  logic [NPUSH-1:0][IW-1:0] push_slot;
  logic [CW-1:0]    n_push;
  logic [CW-1:0]    n_pop;

  // read side: slots never written still hold their reset index
  always_comb begin
    for (int k = 0; k < NPOP; k++) begin
      rd_slot[k] = head_q + IW'(k);
      pop_idx[k] = written_q[rd_slot[k]] ? mem[rd_slot[k]]
                                         : rd_slot[k] + IW'(RESV);
    end
  end

  // write side: compact valid pushes behind the tail
  always_comb begin
    n_push = '0;
    for (int p = 0; p < NPUSH; p++) begin
      push_slot[p] = tail_q + IW'(n_push);
      if (push_vld[p]) n_push = n_push + 1'b1;
    end
  end

  always_comb begin
    n_pop     = pop_en ? CW'(pop_num) : '0;
    head_d    = head_q + IW'(n_pop);
    tail_d    = tail_q + IW'(n_push);
    cnt_d     = cnt_q - n_pop + n_push;
    written_d = written_q;
    for (int p = 0; p < NPUSH; p++)
      if (push_vld[p]) written_d[push_slot[p]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q    <= '0;
      tail_q    <= IW'(DEPTH - RESV);
      cnt_q     <= CW'(DEPTH - RESV);
      written_q <= '0;
    end else begin
      head_q    <= head_d;
      tail_q    <= tail_d;
      cnt_q     <= cnt_d;
      written_q <= written_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NPUSH; p++)
      if (push_vld[p]) mem[push_slot[p]] <= push_idx[p];
  end

  assign avail = cnt_q;

  // R7: returned registers never overfill the subset
  assert_avail_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R6: the renamer only pops what the list holds
  assert_pop_cover_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> (CW'(pop_num) <= cnt_q));
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int LREGS = 32,
  parameter int NSUB  = 4,
  parameter int TAGW  = 9,
  parameter int NRD   = 8,
  parameter int NWR   = 4,
  localparam int LW   = $clog2(LREGS),
  localparam int SW   = $clog2(NSUB),
  localparam int IW   = TAGW - SW
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NRD-1:0][LW-1:0]     rd_addr,
  output logic [NRD-1:0][TAGW-1:0]   rd_tag,
  input  logic                       wr_en,
  input  logic [NWR-1:0][LW-1:0]     wr_addr,
  input  logic [NWR-1:0][TAGW-1:0]   wr_tag
);
  logic [TAGW-1:0] map_q [LREGS];
  logic [TAGW-1:0] map_d [LREGS];

  function automatic logic [TAGW-1:0] home_tag(input int r);
    logic [SW-1:0] s;
    logic [IW-1:0] i;
    s = SW'(r % NSUB);
    i = IW'(r / NSUB);
    return {s, i};
  endfunction

  always_comb begin
    for (int r = 0; r < NRD; r++) rd_tag[r] = map_q[rd_addr[r]];
  end

  // later slots override earlier ones: last writer wins
  always_comb begin
    map_d = map_q;
    for (int w = 0; w < NWR; w++) map_d[wr_addr[w]] = wr_tag[w];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < LREGS; r++) map_q[r] <= home_tag(r);
    end else if (wr_en) begin
      map_q <= map_d;
    end
  end
endmodule

// File: rtl/rn_dep_resolve.sv
module rn_dep_resolve #(
  parameter int GRP  = 4,
  parameter int LW   = 5,
  parameter int TAGW = 9
) (
  input  logic [GRP-1:0][LW-1:0]    src_a,
  input  logic [GRP-1:0][LW-1:0]    src_b,
  input  logic [GRP-1:0][LW-1:0]    dst,
  input  logic [GRP-1:0][TAGW-1:0]  dst_tag,
  input  logic [GRP-1:0][TAGW-1:0]  tbl_a,
  input  logic [GRP-1:0][TAGW-1:0]  tbl_b,
  output logic [GRP-1:0][TAGW-1:0]  phys_a,
  output logic [GRP-1:0][TAGW-1:0]  phys_b
);
  always_comb begin
    for (int i = 0; i < GRP; i++) begin
      phys_a[i] = tbl_a[i];
      phys_b[i] = tbl_b[i];
      for (int k = 0; k < i; k++) begin
        if (dst[k] == src_a[i]) phys_a[i] = dst_tag[k];
        if (dst[k] == src_b[i]) phys_b[i] = dst_tag[k];
      end
    end
  end
endmodule

// File: rtl/subset_renamer.sv
module subset_renamer
  import rn_pkg::*;
#(
  parameter int GRP       = GRP_N,
  parameter int NSUB      = SUB_N,
  parameter int LREGS     = LREG_N,
  parameter int DEPTH     = SUB_DEPTH,
  parameter int NREL      = REL_N,
  localparam int SW       = $clog2(NSUB),
  localparam int IW       = $clog2(DEPTH),
  localparam int TAGW     = SW + IW,
  localparam int LW       = $clog2(LREGS),
  localparam int RESV     = LREGS / NSUB,
  localparam int CW       = $clog2(DEPTH + 1),
  localparam int NW       = $clog2(GRP + 1),
  localparam int RW       = (GRP > 1) ? $clog2(GRP) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      grp_valid,
  input  logic [GRP-1:0][LW-1:0]    grp_src_a,
  input  logic [GRP-1:0][LW-1:0]    grp_src_b,
  input  logic [GRP-1:0][LW-1:0]    grp_dst,
  input  logic [GRP-1:0][SW-1:0]    grp_sub,
  input  logic [NREL-1:0]           rel_valid,
  input  logic [NREL-1:0][TAGW-1:0] rel_tag,
  output logic                      grp_stall,
  output logic [GRP-1:0][TAGW-1:0]  phys_src_a,
  output logic [GRP-1:0][TAGW-1:0]  phys_src_b,
  output logic [GRP-1:0][TAGW-1:0]  phys_dst
);
  logic rst_s;
  logic short_any;
  logic fire;
  logic [NSUB-1:0][NW-1:0]          demand;
  logic [NSUB-1:0][CW-1:0]          avail;
  logic [NSUB-1:0][GRP-1:0][IW-1:0] pop_idx;
  logic [NSUB-1:0][NREL-1:0]        push_vld;
  logic [NREL-1:0][IW-1:0]          push_idx;
  logic [GRP-1:0][RW-1:0]           rank;
  logic [2*GRP-1:0][LW-1:0]         rd_addr;
  logic [2*GRP-1:0][TAGW-1:0]       rd_tag;

  rn_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s)
  );

  // per-subset demand and each destination's rank within its subset
  always_comb begin
    for (int s = 0; s < NSUB; s++) begin
      demand[s] = '0;
      for (int i = 0; i < GRP; i++)
        if (grp_sub[i] == SW'(s)) demand[s] = demand[s] + 1'b1;
    end
    for (int i = 0; i < GRP; i++) begin
      rank[i] = '0;
      for (int k = 0; k < i; k++)
        if (grp_sub[k] == grp_sub[i]) rank[i] = rank[i] + 1'b1;
    end
  end

  always_comb begin
    short_any = 1'b0;
    for (int s = 0; s < NSUB; s++)
      if (avail[s] < CW'(demand[s])) short_any = 1'b1;
  end

  assign grp_stall = grp_valid & short_any;
  assign fire      = grp_valid & ~short_any;

  // release routing by subset bits
  always_comb begin
    for (int p = 0; p < NREL; p++) begin
      push_idx[p] = rel_tag[p][IW-1:0];
      for (int s = 0; s < NSUB; s++)
        push_vld[s][p] = rel_valid[p] & (rel_tag[p][TAGW-1 -: SW] == SW'(s));
    end
  end

  for (genvar s = 0; s < NSUB; s++) begin : g_sub
    rn_free_list #(
      .DEPTH(DEPTH), .RESV(RESV), .NPOP(GRP), .NPUSH(NREL)
    ) u_fl (
      .clk     (clk),
      .rst_n   (rst_s),
      .pop_en  (fire),
      .pop_num (demand[s]),
      .push_vld(push_vld[s]),
      .push_idx(push_idx),
      .pop_idx (pop_idx[s]),
      .avail   (avail[s])
    );
  end

  always_comb begin
    for (int i = 0; i < GRP; i++)
      phys_dst[i] = {grp_sub[i], pop_idx[grp_sub[i]][rank[i]]};
  end

  always_comb begin
    for (int i = 0; i < GRP; i++) begin
      rd_addr[i]       = grp_src_a[i];
      rd_addr[GRP + i] = grp_src_b[i];
    end
  end

  rn_map_table #(
    .LREGS(LREGS), .NSUB(NSUB), .TAGW(TAGW), .NRD(2*GRP), .NWR(GRP)
  ) u_map (
    .clk    (clk),
    .rst_n  (rst_s),
    .rd_addr(rd_addr),
    .rd_tag (rd_tag),
    .wr_en  (fire),
    .wr_addr(grp_dst),
    .wr_tag (phys_dst)
  );

  rn_dep_resolve #(.GRP(GRP), .LW(LW), .TAGW(TAGW)) u_dep (
    .src_a  (grp_src_a),
    .src_b  (grp_src_b),
    .dst    (grp_dst),
    .dst_tag(phys_dst),
    .tbl_a  (rd_tag[GRP-1:0]),
    .tbl_b  (rd_tag[2*GRP-1:GRP]),
    .phys_a (phys_src_a),
    .phys_b (phys_src_b)
  );

  // R1: same-subset destinations of an accepted group never collide
  for (genvar i = 0; i < GRP; i++) begin : g_uq_i
    for (genvar j = i + 1; j < GRP; j++) begin : g_uq_j
      assert_dst_unique_R1: assert property (@(posedge clk) disable iff (!rst_s)
        (fire && grp_sub[i] == grp_sub[j]) |-> (phys_dst[i] != phys_dst[j]));
    end
  end

  // R3: a source fed by the immediately preceding slot takes its new tag
  for (genvar i = 1; i < GRP; i++) begin : g_fw
    assert_fwd_prev_R3: assert property (@(posedge clk) disable iff (!rst_s)
      (grp_src_a[i] == grp_dst[i-1]) |-> (phys_src_a[i] == phys_dst[i-1]));
  end

  // R9: no stall without a group
  assert_idle_nostall_R9: assert property (@(posedge clk) disable iff (!rst_s)
    !grp_valid |-> !grp_stall);
endmodule

// File: tb/tb_subset_renamer.sv
module tb_subset_renamer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic grp_valid = 1'b0;
  logic [3:0][4:0] grp_src_a = '0, grp_src_b = '0, grp_dst = '0;
  logic [3:0][1:0] grp_sub = '0;
  logic [3:0]      rel_valid = '0;
  logic [3:0][8:0] rel_tag = '0;
  logic            grp_stall;
  logic [3:0][8:0] phys_src_a, phys_src_b, phys_dst;

  int n_chk = 0;
  int n_fail = 0;
  int fq [4][$];
  int relq [$];
  int mdl_map [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  subset_renamer dut (
    .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid),
    .grp_src_a(grp_src_a), .grp_src_b(grp_src_b), .grp_dst(grp_dst),
    .grp_sub(grp_sub), .rel_valid(rel_valid), .rel_tag(rel_tag),
    .grp_stall(grp_stall), .phys_src_a(phys_src_a),
    .phys_src_b(phys_src_b), .phys_dst(phys_dst)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int home(input int r);
    return (r % 4) * 128 + r / 4;
  endfunction

  // one cycle: drive, check combinational outputs, update model at edge
  task automatic step(input bit v,
                      input logic [3:0][4:0] sa, input logic [3:0][4:0] sb,
                      input logic [3:0][4:0] d,  input logic [3:0][1:0] su,
                      input logic [3:0] rv, input logic [3:0][8:0] rt,
                      input string rq_dst, input string rq_src, input string rq_stall);
    int dem [4];
    int etag [4];
    bit known [4];
    bit shrt;
    bit fire;
    grp_valid = v; grp_src_a = sa; grp_src_b = sb; grp_dst = d; grp_sub = su;
    rel_valid = rv; rel_tag = rt;
    #(CLK_PERIOD/4);
    for (int s = 0; s < 4; s++) dem[s] = 0;
    for (int i = 0; i < 4; i++) begin
      int rk;
      rk = 0;
      for (int k = 0; k < i; k++) if (su[k] == su[i]) rk++;
      dem[su[i]]++;
      known[i] = rk < fq[su[i]].size();
      etag[i]  = known[i] ? int'(su[i]) * 128 + fq[su[i]][rk] : 0;
    end
    shrt = 0;
    for (int s = 0; s < 4; s++) if (fq[s].size() < dem[s]) shrt = 1;
    fire = v && !shrt;
    chk(grp_stall === (v && shrt), rq_stall, grp_stall, v && shrt);
    if (fire) begin
      for (int i = 0; i < 4; i++) begin
        chk(phys_dst[i] === 9'(etag[i]), rq_dst, phys_dst[i], etag[i]);
        chk(phys_dst[i][8:7] === su[i], "R1", phys_dst[i][8:7], su[i]);
      end
    end
    for (int i = 0; i < 4; i++) begin
      int ea, eb;
      bit ok_a, ok_b, fa, fb;
      ea = mdl_map[sa[i]]; eb = mdl_map[sb[i]];
      ok_a = 1; ok_b = 1; fa = 0; fb = 0;
      for (int k = 0; k < i; k++) begin
        if (d[k] == sa[i]) begin ea = etag[k]; ok_a = known[k]; fa = 1; end
        if (d[k] == sb[i]) begin eb = etag[k]; ok_b = known[k]; fb = 1; end
      end
      if (ok_a) chk(phys_src_a[i] === 9'(ea), fa ? "R3" : rq_src, phys_src_a[i], ea);
      if (ok_b) chk(phys_src_b[i] === 9'(eb), fb ? "R3" : rq_src, phys_src_b[i], eb);
    end
    if (fire) begin
      for (int s = 0; s < 4; s++)
        for (int n = 0; n < dem[s]; n++) void'(fq[s].pop_front());
      for (int i = 0; i < 4; i++) begin
        relq.push_back(mdl_map[d[i]]);
        mdl_map[d[i]] = etag[i];
      end
    end
    for (int p = 0; p < 4; p++)
      if (rv[p]) fq[rt[p][8:7]].push_back(int'(rt[p][6:0]));
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [3:0][4:0] sa, sb, d;
    logic [3:0][1:0] su;
    logic [3:0]      rv;
    logic [3:0][8:0] rt;
    void'($urandom(32'd20240611));
    for (int r = 0; r < 32; r++) mdl_map[r] = home(r);
    for (int s = 0; s < 4; s++) for (int i = 8; i < 128; i++) fq[s].push_back(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: reset mapping seen through idle reads
    for (int c = 0; c < 8; c++) begin
      for (int i = 0; i < 4; i++) begin
        sa[i] = 5'(4*c + i); sb[i] = 5'(31 - 4*c - i);
        d[i] = 5'(i + 8); su[i] = 2'(i);
      end
      step(0, sa, sb, d, su, '0, '0, "R2", "R8", "R9");
    end

    // R3/R5: chained group, first pops are index 8 (R8)
    sa = {5'd0, 5'd6, 5'd5, 5'd1}; sb = {5'd6, 5'd5, 5'd2, 5'd3};
    d  = {5'd5, 5'd5, 5'd6, 5'd5}; su = {2'd2, 2'd0, 2'd1, 2'd0};
    step(1, sa, sb, d, su, '0, '0, "R8", "R4", "R6");
    sa = {5'd6, 5'd6, 5'd5, 5'd5}; sb = '0;
    step(0, sa, sb, d, su, '0, '0, "R2", "R5", "R9");

    // R9: idle cycle with destinations set must not touch the table
    d = {5'd5, 5'd6, 5'd7, 5'd8}; su = '1;
    step(0, '0, '0, d, su, '0, '0, "R2", "R9", "R9");
    sa = {5'd5, 5'd6, 5'd7, 5'd8};
    step(0, sa, sa, '0, '0, '0, '0, "R2", "R9", "R9");

    // R6: drain subset 3
    su = '1;
    while (fq[3].size() >= 4) begin
      for (int i = 0; i < 4; i++) begin
        d[i] = 5'($urandom_range(31)); sa[i] = 5'($urandom_range(31));
        sb[i] = 5'($urandom_range(31));
      end
      step(1, sa, sb, d, su, '0, '0, "R2", "R4", "R6");
    end
    // stalled group while releasing four subset-3 registers
    rv = '0; rt = '0;
    begin
      int p;
      p = 0;
      for (int k = relq.size() - 1; k >= 0 && p < 4; k--) begin
        if (relq[k] / 128 == 3) begin
          rt[p] = 9'(relq[k]); rv[p] = 1'b1; relq.delete(k); p++;
        end
      end
    end
    d = {5'd1, 5'd2, 5'd3, 5'd4};
    step(1, d, d, d, su, rv, rt, "R2", "R6", "R6");
    // table unchanged after the stall
    step(0, d, d, '0, '0, '0, '0, "R2", "R6", "R9");
    // released entries come back in port order
    step(1, d, d, d, su, '0, '0, "R7", "R4", "R6");

    // random stream
    for (int n = 0; n < 3000; n++) begin
      bit v;
      v = ($urandom_range(9) != 0);
      for (int i = 0; i < 4; i++) begin
        d[i]  = 5'($urandom_range(31));
        sa[i] = ($urandom_range(2) == 0) ? d[$urandom_range(3)] : 5'($urandom_range(31));
        sb[i] = 5'($urandom_range(31));
        su[i] = ($urandom_range(3) == 0) ? 2'd1 : 2'($urandom_range(3));
      end
      rv = '0; rt = '0;
      for (int p = 0; p < 4; p++) begin
        if (relq.size() > 0 && $urandom_range(4) != 0) begin
          int ix;
          ix = $urandom_range(relq.size() - 1);
          rt[p] = 9'(relq[ix]); rv[p] = 1'b1; relq.delete(ix);
        end
      end
      step(v, sa, sb, d, su, rv, rt, "R2", "R4", "R6");
    end

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule